// File: doc/BRIEF.md
# Interrupt return flag restorer

This block performs the stack-unwinding and flag-rebuild step of leaving an interrupt procedure. After `start_i`, it reads three 32-bit words from a stack read port: the return instruction pointer, the code selector slot and the saved flags image. It then returns the updated stack pointer together with the restored pointer, selector and flags word. Each of the three words moves the stack pointer by one 4-byte slot. The return therefore removes one more slot than a plain far return does.

The new flags word is mostly the saved image. The I/O privilege field and the interrupt-enable bit are exceptions, and privilege decides whether each one is taken from the image. The current privilege level and the current flags are captured when `start_i` is accepted. All comparisons use those captured values, never a flags value being written by the same return. Bits that the architecture keeps at fixed values are forced, whatever the stack holds.

Top module: `iret_restore`

## Requirements
- R1: The block issues stack reads at the addresses sp, sp+4 and sp+8, in that order, for the pointer, the selector and the flags. `stk_req_o` stays high with a stable `stk_addr_o` until `stk_valid_i` accepts the word. Requests are made only while `busy_o` is high.
- R2: At `done_o`, `new_sp_o` equals the captured sp plus 12 (modulo 2^32).
- R3: At `done_o`, `new_ip_o` equals the first word read, and `new_cs_o` equals bits 15:0 of the second word.
- R4: Flags bits 13:12 (I/O privilege) come from the saved image when the captured privilege level is 0. For any other level they keep the captured current value.
- R5: Flags bit 9 (interrupt enable) comes from the saved image when the captured privilege level is less than or equal to bits 13:12 of the captured current flags. Otherwise it keeps the captured current value.
- R6: Bit 8 (trace) is always copied from the saved image. So are bits 0, 2, 4, 6, 7, 10, 11, 14 and 16 to 21.
- R7: In the restored flags, bit 1 is 1, and bits 3, 5, 15 and 22 to 31 are 0.
- R8: `busy_o` rises in the cycle after `start_i` is sampled and stays high until the `done_o` cycle, inclusive. `done_o` is a single-cycle pulse in the cycle after the flags word is accepted.
- R9: `start_i`, `sp_i`, `cpl_i` and `cur_flags_i` are ignored while `busy_o` is high.
- R10: While `rst_ni` is low, `busy_o`, `done_o` and `stk_req_o` are 0, and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a return sequence (sampled when idle) |
| sp_i | input | 32 | Stack pointer at start |
| cpl_i | input | 2 | Current privilege level |
| cur_flags_i | input | 32 | Current flags word |
| stk_req_o | output | 1 | Stack read request |
| stk_addr_o | output | 32 | Stack read address |
| stk_valid_i | input | 1 | Read data valid; accepts the pending request |
| stk_rdata_i | input | 32 | Stack read data |
| new_ip_o | output | 32 | Restored instruction pointer |
| new_cs_o | output | 16 | Restored code selector |
| new_flags_o | output | 32 | Restored flags word |
| new_sp_o | output | 32 | Updated stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest condition to reach is R9: a return whose privilege inputs change in the middle of the sequence. A wrong design would then apply those new inputs to the flag merge. To create it, the bench holds `start_i` high for the whole busy window and drives bit-inverted sp, privilege and flags values, with stack latencies of 0 to 2 wait cycles. Every privilege level is paired with I/O privilege fields below, equal to and above it, so both sides of the R4 and R5 comparisons are covered. A wrap-around stack pointer covers R2.

// File: rtl/iret_pkg.sv
package iret_pkg;
  localparam int FL_W    = 32;
  localparam int IF_BIT  = 9;
  localparam int IOPL_LO = 12;
  localparam int IOPL_HI = 13;
  // fixed-value flag bits
  localparam logic [FL_W-1:0] RSVD_ONE  = 32'h0000_0002;
  localparam logic [FL_W-1:0] RSVD_ZERO = 32'hFFC0_8028;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_FL,
    ST_FIN
  } iret_state_e;
endpackage

// File: rtl/iret_flag_merge.sv
module iret_flag_merge
  import iret_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [1:0]      cpl_i,
  input  logic [FL_W-1:0] cur_flags_i,
  input  logic [FL_W-1:0] saved_i,
  output logic [FL_W-1:0] flags_o
);
  logic [FL_W-1:0] merged;
  logic [1:0]      cur_iopl;

  assign cur_iopl = cur_flags_i[IOPL_HI:IOPL_LO];

  always_comb begin
    merged = (saved_i & ~RSVD_ZERO) | RSVD_ONE;
    if (cpl_i != 2'd0) merged[IOPL_HI:IOPL_LO] = cur_iopl;
    if (cpl_i > cur_iopl) merged[IF_BIT] = cur_flags_i[IF_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_o <= '0;
    else if (load_i) flags_o <= merged;
  end

  AST_IOPL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (cpl_i != 2'd0) |=> flags_o[IOPL_HI:IOPL_LO] == $past(cur_flags_i[IOPL_HI:IOPL_LO])); // R4
  AST_IF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (cpl_i > cur_flags_i[IOPL_HI:IOPL_LO]) |=> flags_o[IF_BIT] == $past(cur_flags_i[IF_BIT])); // R5
  AST_RSVD_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> flags_o[1] && ((flags_o & RSVD_ZERO) == '0)); // R7
endmodule

// File: rtl/iret_seq.sv
module iret_seq
  import iret_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SLOT_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [1:0]        cpl_i,
  input  logic [FL_W-1:0]   cur_flags_i,
  output logic              stk_req_o,
  output logic [ADDR_W-1:0] stk_addr_o,
  input  logic              stk_valid_i,
  input  logic [FL_W-1:0]   stk_rdata_i,
  output logic              fl_load_o,
  output logic [1:0]        cpl_o,
  output logic [FL_W-1:0]   cur_flags_o,
  output logic [FL_W-1:0]   ip_o,
  output logic [15:0]       cs_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(SLOT_BYTES);

  iret_state_e     state_q;
  logic [ADDR_W-1:0] sp_q;
  logic              accept;

  assign stk_req_o  = (state_q == ST_POP_IP) || (state_q == ST_POP_CS) || (state_q == ST_POP_FL);
  assign accept     = stk_req_o && stk_valid_i;
  assign fl_load_o  = (state_q == ST_POP_FL) && stk_valid_i;
  assign stk_addr_o = sp_q;
  assign sp_o       = sp_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sp_q        <= '0;
      cpl_o       <= '0;
      cur_flags_o <= '0;
      ip_o        <= '0;
      cs_o        <= '0;
    end else begin
      if (accept) sp_q <= sp_q + SLOT;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sp_q        <= sp_i;
          cpl_o       <= cpl_i;
          cur_flags_o <= cur_flags_i;
          state_q     <= ST_POP_IP;
        end
        ST_POP_IP: if (stk_valid_i) begin
          ip_o    <= stk_rdata_i;
          state_q <= ST_POP_CS;
        end
        ST_POP_CS: if (stk_valid_i) begin
          cs_o    <= stk_rdata_i[15:0];
          state_q <= ST_POP_FL;
        end
        ST_POP_FL: if (stk_valid_i) state_q <= ST_FIN;
        ST_FIN:    state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_req_o |-> busy_o); // R1
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_req_o && !stk_valid_i |=> stk_req_o && $stable(stk_addr_o)); // R1
  AST_SP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> stk_addr_o == $past(stk_addr_o) + SLOT); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R8
  AST_CTX_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cpl_o) && $stable(cur_flags_o)); // R9
endmodule

// File: rtl/iret_restore.sv
module iret_restore
  import iret_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SLOT_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [1:0]        cpl_i,
  input  logic [31:0]       cur_flags_i,
  output logic              stk_req_o,
  output logic [ADDR_W-1:0] stk_addr_o,
  input  logic              stk_valid_i,
  input  logic [31:0]       stk_rdata_i,
  output logic [31:0]       new_ip_o,
  output logic [15:0]       new_cs_o,
  output logic [31:0]       new_flags_o,
  output logic [ADDR_W-1:0] new_sp_o,
  output logic              busy_o,
  output logic              done_o
);
  logic            fl_load;
  logic [1:0]      cpl_q;
  logic [FL_W-1:0] cur_q;

  iret_seq #(
    .ADDR_W     (ADDR_W),
    .SLOT_BYTES (SLOT_BYTES)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .sp_i        (sp_i),
    .cpl_i       (cpl_i),
    .cur_flags_i (cur_flags_i),
    .stk_req_o   (stk_req_o),
    .stk_addr_o  (stk_addr_o),
    .stk_valid_i (stk_valid_i),
    .stk_rdata_i (stk_rdata_i),
    .fl_load_o   (fl_load),
    .cpl_o       (cpl_q),
    .cur_flags_o (cur_q),
    .ip_o        (new_ip_o),
    .cs_o        (new_cs_o),
    .sp_o        (new_sp_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  iret_flag_merge u_merge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (fl_load),
    .cpl_i       (cpl_q),
    .cur_flags_i (cur_q),
    .saved_i     (stk_rdata_i),
    .flags_o     (new_flags_o)
  );
endmodule

// File: tb/iret_restore_bench.sv
module iret_restore_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] sp_i = '0;
  logic [1:0]  cpl_i = '0;
  logic [31:0] cur_flags_i = '0;
  logic        stk_req_o;
  logic [31:0] stk_addr_o;
  logic        stk_valid_i = 1'b0;
  logic [31:0] stk_rdata_i = '0;
  logic [31:0] new_ip_o, new_flags_o, new_sp_o;
  logic [15:0] new_cs_o;
  logic        busy_o, done_o;

  always #2.5 clk = ~clk;

  iret_restore u_iret_restore (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .sp_i(sp_i), .cpl_i(cpl_i),
    .cur_flags_i(cur_flags_i), .stk_req_o(stk_req_o), .stk_addr_o(stk_addr_o),
    .stk_valid_i(stk_valid_i), .stk_rdata_i(stk_rdata_i), .new_ip_o(new_ip_o),
    .new_cs_o(new_cs_o), .new_flags_o(new_flags_o), .new_sp_o(new_sp_o),
    .busy_o(busy_o), .done_o(done_o));

  int n_chk = 0, n_fail = 0, cyc = 0, lat = 0, wcnt = 0, pops = 0;
  bit ended = 0, m_busy = 0, m_fin = 0;
  logic [31:0] f_ip, f_cs, f_fl, m_sp0, m_cur;
  logic [1:0]  m_cpl;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_flags(input logic [1:0] cpl, input logic [31:0] cur, input logic [31:0] sv);
    logic [31:0] e = sv;
    e[1] = 1'b1; e[3] = 1'b0; e[5] = 1'b0; e[15] = 1'b0; e[31:22] = '0;
    if (cpl != 0) e[13:12] = cur[13:12];
    if (cpl > cur[13:12]) e[9] = cur[9];
    return e;
  endfunction

  // behavioural model of the handshake
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_fin = 0; pops = 0;
    end else if (m_fin) begin
      m_fin = 0; m_busy = 0;
    end else if (m_busy) begin
      if (stk_valid_i) begin
        pops++;
        if (pops == 3) m_fin = 1;
      end
    end else if (start_i) begin
      m_busy = 1; pops = 0; m_sp0 = sp_i; m_cpl = cpl_i; m_cur = cur_flags_i;
    end
  end

  // per-cycle comparison and stack responder
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk(busy_o == m_busy, "R8 busy", 32'(busy_o), 32'(m_busy));
      chk(done_o == m_fin, "R8 done", 32'(done_o), 32'(m_fin));
      chk(stk_req_o == (m_busy && !m_fin), "R1 req", 32'(stk_req_o), 32'(m_busy && !m_fin));
      if (stk_req_o)
        chk(stk_addr_o == m_sp0 + 32'(4 * pops), "R1 addr", stk_addr_o, m_sp0 + 32'(4 * pops));
      if (m_fin) begin
        logic [31:0] e;
        e = ref_flags(m_cpl, m_cur, f_fl);
        chk(new_sp_o == m_sp0 + 32'd12, "R2 sp", new_sp_o, m_sp0 + 32'd12);
        chk(new_ip_o == f_ip, "R3 ip", new_ip_o, f_ip);
        chk(new_cs_o == f_cs[15:0], "R3 cs", 32'(new_cs_o), 32'(f_cs[15:0]));
        chk(new_flags_o[13:12] == e[13:12], "R4 iopl", 32'(new_flags_o[13:12]), 32'(e[13:12]));
        chk(new_flags_o[9] == e[9], "R5 if", 32'(new_flags_o[9]), 32'(e[9]));
        chk((new_flags_o & 32'h003F_4DD5) == (e & 32'h003F_4DD5), "R6 copied", new_flags_o, e);
        chk(new_flags_o[1] && ((new_flags_o & 32'hFFC0_8028) == 0), "R7 fixed", new_flags_o, e);
      end
    end
    if (!rst_n) begin
      stk_valid_i = 0; wcnt = 0;
    end else if (stk_valid_i) begin
      stk_valid_i = 0; wcnt = 0;
    end else if (stk_req_o) begin
      if (wcnt >= lat) begin
        stk_valid_i = 1;
        stk_rdata_i = (stk_addr_o == m_sp0) ? f_ip :
                      (stk_addr_o == m_sp0 + 32'd4) ? f_cs :
                      (stk_addr_o == m_sp0 + 32'd8) ? f_fl : 32'hDEAD_BEEF;
      end else wcnt++;
    end
  end

  task automatic run_ret(input logic [31:0] sp, input logic [1:0] cpl, input logic [31:0] cur,
                         input logic [31:0] ip, input logic [31:0] cs, input logic [31:0] fl,
                         input int l, input bit hold);
    @(negedge clk);
    f_ip = ip; f_cs = cs; f_fl = fl; lat = l;
    sp_i = sp; cpl_i = cpl; cur_flags_i = cur; start_i = 1;
    @(negedge clk);
    if (hold) begin
      sp_i = ~sp; cpl_i = ~cpl; cur_flags_i = ~cur; // R9: changes while busy
    end else start_i = 0;
    while (!done_o) @(negedge clk);
    start_i = 0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy_o && !done_o && !stk_req_o, "R10 ctrl", {busy_o, done_o, stk_req_o}, 0);
    chk(new_sp_o == 0 && new_ip_o == 0 && new_flags_o == 0 && new_cs_o == 0, "R10 data",
        new_flags_o, 0);
    rst_n = 1;
    @(negedge clk);
    for (int c = 0; c < 4; c++)
      for (int io = 0; io < 4; io++)
        run_ret(32'h0000_1000 + 32'(c * 64 + io * 16), 2'(c), 32'h0000_0202 ^ (32'(io) << 12),
                32'h1234_0000 + 32'(c), 32'hABCD_0008 + 32'(io), 32'hFFFF_FFFF ^ (32'(io) << 12),
                (c + io) % 3, 1'b0);
    run_ret(32'hFFFF_FFF8, 2'd0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 0, 1'b0); // R2 wrap
    for (int k = 0; k < 30; k++)
      run_ret($urandom, 2'($urandom), $urandom, $urandom, $urandom, $urandom,
              k % 3, (k % 2) == 1); // R9 on odd runs
    run_ret(32'h0000_2000, 2'd3, 32'h0000_2000, 32'h1, 32'h2, 32'h0000_3300, 2, 1'b1);
    repeat (4) @(negedge clk);
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule